// File: doc/BRIEF.md
# Dual-Channel Phase-Frequency Detector with Lock Monitor

This block is the digital core of a two-channel frequency synthesizer. Each channel compares a reference pulse stream with a divided-down feedback pulse stream and commands an external charge pump. It does so through two enables: one sources current and one sinks it. When both enables are off the pump output is high-impedance. A per-channel polarity input decides which enable the leading reference drives, which suits loop filters and oscillators of either tuning slope.

A lock detector per channel measures each comparison's phase error as a count of oscillator-clock cycles. It applies hysteresis. A single wide error drops lock at once, while lock needs a run of three narrow comparisons. The two channel lock states are combined into one flag, and a channel held in power save counts as locked. A shared monitor output carries either that flag or one of the four raw comparator inputs. The charge-pump current select bits only pass through the block.

Top module: `dual_pfd_lock`

## Requirements
- R1: With the polarity input high, a reference edge that arrives d clock cycles before the feedback edge holds `pump_src` for d+1 cycles and `pump_snk` for 1 cycle. A feedback edge arriving first does the mirror image. With no comparison in progress both enables are low.
- R2: With the polarity input low, the roles of `pump_src` and `pump_snk` in R1 are exchanged.
- R3: Each comparison ends with exactly one clock cycle in which `pump_src` and `pump_snk` are both high, including when the two edges coincide. This cycle is the anti-dead-zone pulse.
- R4: A channel loses lock as soon as its phase error reaches 3 or more clock cycles, with either input leading.
- R5: A channel gains lock at the end of the third consecutive comparison whose error is 1 cycle or less. An error of exactly 2 cycles neither drops lock nor counts, and it restarts the run.
- R6: With `mon_sel` low, `mon_out` is high only when each channel is locked or has `pwr_on` low.
- R7: While `pwr_on` of a channel is low, both of its pump enables stay low whatever its inputs do. Its detector and lock state are cleared, so it comes back unlocked.
- R8: The first comparison after reset or after leaving power save drives its pump for only one cycle. That comparison does not count toward lock.
- R9: With `mon_sel` high, `tap_sel[0]` picks the channel (0 or 1) and `tap_sel[1]` picks the signal, with 0 for the reference and 1 for the feedback. `mon_out` then follows the selected input.
- R10: `cur_out` equals `cur_sel` for both channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; phase error is counted in its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_in | input | 2 | Reference pulse per channel, synchronous to clk |
| fb_in | input | 2 | Feedback pulse per channel, synchronous to clk |
| pwr_on | input | 2 | Per channel: 1 normal, 0 power save |
| pol_pos | input | 2 | Per channel polarity: 1 reference-lead sources, 0 reference-lead sinks |
| cur_sel | input | 2 | Per channel pump current select |
| mon_sel | input | 1 | 0 lock flag on mon_out, 1 monitor tap |
| tap_sel | input | 2 | Monitor tap: bit0 channel, bit1 feedback |
| pump_src | output | 2 | Per channel source enable |
| pump_snk | output | 2 | Per channel sink enable |
| cur_out | output | 2 | Current select pass-through |
| mon_out | output | 1 | Combined lock flag or monitor tap |

## Verification
The assertions take for granted that the pulse inputs are already synchronous to the clock. They also assume that, within one channel, no new rising edge lands on the cycle in which the detector clears its two flops, because such an edge would be dropped. The stimulus therefore sends one reference pulse and one feedback pulse per comparison, each one cycle wide. It leaves at least five idle cycles after the later edge before the next comparison. Monitor-tap sweeps run with both channels in power save, so that the level changes on the pulse inputs cannot disturb any lock state.

// File: rtl/dual_pfd_lock.sv
module dual_pfd_lock #(
  parameter int CNT_W     = 4,
  parameter int UNLOCK_W  = 3,
  parameter int LOCK_W    = 1,
  parameter int LOCK_RUNS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ref_in,
  input  logic [1:0] fb_in,
  input  logic [1:0] pwr_on,
  input  logic [1:0] pol_pos,
  input  logic [1:0] cur_sel,
  input  logic       mon_sel,
  input  logic [1:0] tap_sel,
  output logic [1:0] pump_src,
  output logic [1:0] pump_snk,
  output logic [1:0] cur_out,
  output logic       mon_out
);
  localparam int RUN_W = $clog2(LOCK_RUNS + 1);
  localparam logic [CNT_W-1:0] ERR_MAX  = '1;
  localparam logic [CNT_W-1:0] ERR_TRIP = CNT_W'(UNLOCK_W - 1);
  localparam logic [CNT_W-1:0] ERR_OK   = CNT_W'(LOCK_W);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_RUNS - 1);

  logic [1:0] ch_lock;
  logic       lock_all;

  genvar c;
  generate
    for (c = 0; c < 2; c++) begin : g_ch
      logic r_d, f_d, up, dn, wake, shown, locked, en;
      logic r_edge, f_edge;
      logic [CNT_W-1:0] err;
      logic [RUN_W-1:0] run;

      assign r_edge = ref_in[c] & ~r_d;
      assign f_edge = fb_in[c] & ~f_d;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          r_d <= 1'b0; f_d <= 1'b0; up <= 1'b0; dn <= 1'b0;
          err <= '0; run <= '0; locked <= 1'b0;
          wake <= 1'b1; shown <= 1'b0;
        end else begin
          r_d <= ref_in[c];
          f_d <= fb_in[c];
          if (!pwr_on[c]) begin
            up <= 1'b0; dn <= 1'b0; err <= '0; run <= '0;
            locked <= 1'b0; wake <= 1'b1; shown <= 1'b0;
          end else begin
            if (up && dn) begin
              up <= 1'b0;
              dn <= 1'b0;
            end else begin
              if (r_edge) up <= 1'b1;
              if (f_edge) dn <= 1'b1;
            end
            if (wake) begin
              err <= '0;
              if (up || dn) shown <= 1'b1;
              if (up && dn) begin
                wake  <= 1'b0;
                shown <= 1'b0;
              end
            end else if (up && dn) begin
              err <= '0;
              if (err <= ERR_OK) begin
                if (run >= RUN_LAST) locked <= 1'b1;
                else run <= run + 1'b1;
              end else begin
                run <= '0;
              end
            end else if (up ^ dn) begin
              if (err != ERR_MAX) err <= err + 1'b1;
              if (err >= ERR_TRIP) begin
                locked <= 1'b0;
                run    <= '0;
              end
            end
          end
        end
      end

      assign en          = pwr_on[c] & (~wake | ~shown);
      assign pump_src[c] = en & (pol_pos[c] ? up : dn);
      assign pump_snk[c] = en & (pol_pos[c] ? dn : up);
      assign ch_lock[c]  = locked | ~pwr_on[c];

      p_save_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on[c] |-> !pump_src[c] && !pump_snk[c]);

      p_pair_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (up && dn) |=> !up && !dn);

      p_wide_unlock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_on[c] && !wake && (up ^ dn) && err >= ERR_TRIP) |=> !locked);

      p_lock_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(up && dn));

      p_wake_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wake && (pump_src[c] || pump_snk[c])) |=> !wake || !(pump_src[c] || pump_snk[c]));

      p_unlocked_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_on[c] && !locked) |-> !lock_all);
    end
  endgenerate

  assign lock_all = &ch_lock;
  assign cur_out  = cur_sel;
  assign mon_out  = mon_sel ? (tap_sel[1] ? fb_in[tap_sel[0]] : ref_in[tap_sel[0]]) : lock_all;
endmodule

// File: tb/tb_dual_pfd_lock.sv
module tb_dual_pfd_lock;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] ref_in = '0, fb_in = '0, pwr_on = 2'b11, pol_pos = 2'b11, cur_sel = '0, tap_sel = '0;
  logic mon_sel = 1'b0;
  logic [1:0] pump_src, pump_snk, cur_out;
  logic mon_out;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dual_pfd_lock dut (.clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in), .pwr_on(pwr_on),
    .pol_pos(pol_pos), .cur_sel(cur_sel), .mon_sel(mon_sel), .tap_sel(tap_sel),
    .pump_src(pump_src), .pump_snk(pump_snk), .cur_out(cur_out), .mon_out(mon_out));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_cmp(input int ch, input int lead, output int ns, output int nk, output int nb);
    int a, b, span;
    a = (lead >= 0) ? 0 : -lead;
    b = (lead >= 0) ? lead : 0;
    span = ((lead >= 0) ? lead : -lead) + 6;
    ns = 0; nk = 0; nb = 0;
    for (int k = 0; k <= span; k++) begin
      @(negedge clk);
      ns += int'(pump_src[ch]);
      nk += int'(pump_snk[ch]);
      nb += int'(pump_src[ch] & pump_snk[ch]);
      ref_in[ch] = (k == a);
      fb_in[ch]  = (k == b);
    end
  endtask

  task automatic cmp_lock(input int lead, input int exp, input string tag);
    int s, k, o;
    run_cmp(0, lead, s, k, o);
    chk(tag, int'(mon_out), exp);
  endtask

  initial begin
    int s, k, o, lead_side, other, e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 reset lock low", int'(mon_out), 0);
    chk("R1 reset src idle", int'(pump_src), 0);
    chk("R1 reset snk idle", int'(pump_snk), 0);

    run_cmp(0, 3, s, k, o);
    chk("R8 wake ch0 src", s, 1); chk("R8 wake ch0 snk", k, 0);
    run_cmp(1, -3, s, k, o);
    chk("R8 wake ch1 snk", k, 1); chk("R8 wake ch1 src", s, 0);

    pwr_on[1] = 1'b0;
    for (int p = 1; p >= 0; p--) begin
      pol_pos[0] = p[0];
      for (int d = -4; d <= 4; d++) begin
        run_cmp(0, d, s, k, o);
        lead_side = ((d >= 0) ? d : -d) + 1;
        other = 1;
        if ((d >= 0) == (p == 1)) begin
          chk(p ? "R1 src count" : "R2 src count", s, (d == 0) ? 1 : lead_side);
          chk(p ? "R1 snk count" : "R2 snk count", k, (d == 0) ? 1 : other);
        end else begin
          chk(p ? "R1 src count" : "R2 src count", s, other);
          chk(p ? "R1 snk count" : "R2 snk count", k, lead_side);
        end
        chk("R3 overlap one cycle", o, 1);
      end
    end
    pol_pos[0] = 1'b1;

    cmp_lock(0, 0, "R5 run1"); cmp_lock(0, 0, "R5 run2"); cmp_lock(0, 1, "R5 run3 locks");
    cmp_lock(2, 1, "R5 width2 keeps lock");
    cmp_lock(3, 0, "R4 width3 unlocks");
    cmp_lock(0, 0, "R5 a"); cmp_lock(0, 0, "R5 b"); cmp_lock(2, 0, "R5 width2 restarts");
    cmp_lock(0, 0, "R5 c"); cmp_lock(0, 0, "R5 d"); cmp_lock(0, 1, "R5 relock");
    cmp_lock(-1, 1, "R5 lead -1 narrow"); cmp_lock(1, 1, "R5 lead 1 narrow");
    cmp_lock(-3, 0, "R4 fb-lead unlocks");
    cmp_lock(0, 0, "R5 e"); cmp_lock(1, 0, "R5 f"); cmp_lock(-1, 1, "R5 mixed run locks");

    pwr_on[1] = 1'b1;
    @(negedge clk);
    chk("R6 unlocked ch1 blocks", int'(mon_out), 0);
    run_cmp(1, 2, s, k, o);
    chk("R8 wake pulse src", s, 1); chk("R8 wake pulse snk", k, 0);
    run_cmp(1, 0, s, k, o); run_cmp(1, 0, s, k, o);
    chk("R8 wake cmp not counted", int'(mon_out), 0);
    run_cmp(1, 0, s, k, o);
    chk("R6 both locked", int'(mon_out), 1);

    pwr_on[1] = 1'b0;
    run_cmp(1, 3, s, k, o);
    chk("R7 save src", s, 0); chk("R7 save snk", k, 0);
    chk("R6 saved counts locked", int'(mon_out), 1);
    pwr_on[1] = 1'b1;
    @(negedge clk);
    chk("R7 state cleared", int'(mon_out), 0);
    pwr_on = 2'b00;
    @(negedge clk);
    chk("R6 both saved", int'(mon_out), 1);

    mon_sel = 1'b1;
    for (int p = 0; p < 16; p++) begin
      for (int t = 0; t < 4; t++) begin
        @(negedge clk);
        ref_in = p[1:0]; fb_in = p[3:2]; tap_sel = t[1:0];
        #1;
        e = t[1] ? p[2 + t[0]] : p[t[0]];
        chk("R9 monitor tap", int'(mon_out), e);
      end
    end
    ref_in = '0; fb_in = '0; mon_sel = 1'b0;
    #1 chk("R9 lock select", int'(mon_out), 1);

    for (int v = 0; v < 4; v++) begin
      cur_sel = v[1:0];
      #1 chk("R10 current pass", int'(cur_out), v);
    end

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule